// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which of fifteen message objects takes a received CAN frame. The receive path presents the frame identifier on a 29-bit bus, with a flag that marks an extended frame, and pulses a frame strobe once. One clock later the filter gives a result strobe, a hit flag and the number of the accepting object.

Objects 1 to 14 are general buffers. Each has an identifier, an extended-format bit, an enable bit and a direction bit. Object 15 is a receive-only catch-all. A frame reaches it only when none of the general objects accepts the frame. Its comparison is narrowed further by a local mask of its own.

There are two global masks, one for 11-bit identifiers and one for 29-bit identifiers. A mask bit of 0 marks an identifier bit as "don't care". A mask bit of 1 marks an identifier bit that must match.

Top module: `can_accept_filter`

## Requirements
- R1: While rst_ni is low, and after it is released until the first frame strobe, res_valid_o, hit_o and hit_idx_o are all 0.
- R2: res_valid_o is 1 in exactly the cycle after each cycle in which frame_valid_i is 1, and 0 otherwise.
- R3: For a standard frame, identifier bits 10:0 are compared only where std_mask_i holds a 1. Where std_mask_i holds a 0 the bit is not compared.
- R4: For an extended frame, all 29 identifier bits are compared under ext_mask_i. For a standard frame, frame_id_i bits 28:11 have no effect on the result.
- R5: An object can accept a frame only if all of these hold: its obj_valid_i bit is 1, its obj_ext_i bit equals frame_ext_i, and, for objects 1 to 14, its obj_rx_i bit is 1 (1 = receive, 0 = transmit).
- R6: When several of objects 1 to 14 accept a frame, the lowest-numbered one is reported.
- R7: Object 15 is reported only when no object from 1 to 14 accepts the frame.
- R8: For object 15, an identifier bit is compared only where both the applicable global mask and last_mask_i hold a 1.
- R9: The result is encoded as follows. On acceptance, hit_o is 1 and hit_idx_o holds the object number, 1 to 15. With no acceptance, or with no result strobe, hit_o is 0 and hit_idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle strobe for a received identifier |
| frame_ext_i | input | 1 | 1 = extended (29-bit) frame, 0 = standard (11-bit) frame |
| frame_id_i | input | 29 | Received identifier; a standard identifier sits in bits 10:0 |
| obj_id_i | input | 435 | Object identifiers; object n occupies bits 29*(n-1) +: 29 |
| obj_ext_i | input | 15 | Extended-format bit per object; bit n-1 belongs to object n |
| obj_valid_i | input | 15 | Enable bit per object |
| obj_rx_i | input | 14 | Direction bit for objects 1 to 14 (1 = receive) |
| std_mask_i | input | 11 | Global mask for standard identifiers |
| ext_mask_i | input | 29 | Global mask for extended identifiers |
| last_mask_i | input | 29 | Local mask of object 15; bits 10:0 apply to standard frames |
| res_valid_o | output | 1 | Result strobe |
| hit_o | output | 1 | Frame accepted |
| hit_idx_o | output | 4 | Accepting object number, or 0 |

## Verification
The bench drives several frames that match more than one object. A design that picked the highest-numbered object, or that let the catch-all win over a general buffer, would report the wrong object number.

It also sends a standard frame with junk in the upper identifier bits. A design that compared the full bus would report a miss for that frame.

Object 15 is tested with a differing identifier bit cleared first in only the global mask and then in only the local mask. A design that ORed the two masks, or that ignored one of them, would give the wrong hit or miss in one of those cases.

Frames that fail on the direction bit, the enable bit or the format flag alone are also sent. A design that skipped any of these three checks would report a false hit.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int unsigned CAN_STD_W = 11;
  localparam int unsigned CAN_EXT_W = 29;
  localparam int unsigned CAN_OBJS  = 15;
endpackage

// File: rtl/can_obj_cmp.sv
module can_obj_cmp #(
  parameter int unsigned ID_W = 29
) (
  input  logic [ID_W-1:0] frame_id_i,
  input  logic            frame_ext_i,
  input  logic [ID_W-1:0] obj_id_i,
  input  logic            obj_ext_i,
  input  logic            obj_en_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            match_o
);
  logic [ID_W-1:0] diff;

  always_comb begin
    diff    = (frame_id_i ^ obj_id_i) & mask_i;
    match_o = obj_en_i && (obj_ext_i == frame_ext_i) && (diff == '0);
  end
endmodule

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
  parameter int unsigned N_GEN = 14,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N_GEN-1:0] gen_match_i,
  input  logic             last_match_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = (|gen_match_i) | last_match_i;
    idx_o = '0;
    // catch-all first, then general buffers from high to low so the lowest wins
    if (last_match_i) idx_o = IDX_W'(N_GEN + 1);
    for (int i = N_GEN - 1; i >= 0; i--) begin
      if (gen_match_i[i]) idx_o = IDX_W'(i + 1);
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_OBJ = CAN_OBJS,
  parameter int unsigned ID_W    = CAN_EXT_W,
  parameter int unsigned STD_W   = CAN_STD_W,
  localparam int unsigned N_GEN  = NUM_OBJ - 1,
  localparam int unsigned IDX_W  = $clog2(NUM_OBJ + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_valid_i,
  input  logic                    frame_ext_i,
  input  logic [ID_W-1:0]         frame_id_i,
  input  logic [NUM_OBJ*ID_W-1:0] obj_id_i,
  input  logic [NUM_OBJ-1:0]      obj_ext_i,
  input  logic [NUM_OBJ-1:0]      obj_valid_i,
  input  logic [N_GEN-1:0]        obj_rx_i,
  input  logic [STD_W-1:0]        std_mask_i,
  input  logic [ID_W-1:0]         ext_mask_i,
  input  logic [ID_W-1:0]         last_mask_i,
  output logic                    res_valid_o,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        hit_idx_o
);
  logic [ID_W-1:0]    glob_mask;
  logic [NUM_OBJ-1:0] match;
  logic               any_hit;
  logic [IDX_W-1:0]   pick_idx;

  // standard frames: upper bus bits masked out entirely
  always_comb begin
    if (frame_ext_i) glob_mask = ext_mask_i;
    else             glob_mask = {{(ID_W-STD_W){1'b0}}, std_mask_i};
  end

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic            en;
    logic [ID_W-1:0] msk;
    if (g < N_GEN) begin : g_gen
      assign en  = obj_valid_i[g] & obj_rx_i[g];
      assign msk = glob_mask;
    end else begin : g_last
      assign en  = obj_valid_i[g];
      assign msk = glob_mask & last_mask_i;
    end
    can_obj_cmp #(.ID_W(ID_W)) u_cmp (
      .frame_id_i  (frame_id_i),
      .frame_ext_i (frame_ext_i),
      .obj_id_i    (obj_id_i[g*ID_W +: ID_W]),
      .obj_ext_i   (obj_ext_i[g]),
      .obj_en_i    (en),
      .mask_i      (msk),
      .match_o     (match[g])
    );
  end

  can_prio_pick #(.N_GEN(N_GEN), .IDX_W(IDX_W)) u_pick (
    .gen_match_i  (match[N_GEN-1:0]),
    .last_match_i (match[NUM_OBJ-1] & ~(|match[N_GEN-1:0])),
    .any_o        (any_hit),
    .idx_o        (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      hit_idx_o   <= '0;
    end else begin
      res_valid_o <= frame_valid_i;
      hit_o       <= frame_valid_i & any_hit;
      hit_idx_o   <= (frame_valid_i && any_hit) ? pick_idx : '0;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int unsigned NUM_OBJ = 15,
  parameter int unsigned IDX_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_valid_i,
  input logic [NUM_OBJ-1:0] obj_valid_i,
  input logic               res_valid_o,
  input logic               hit_o,
  input logic [IDX_W-1:0]   hit_idx_o
);
  logic [NUM_OBJ-1:0] prev_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_valid <= '0;
    else         prev_valid <= obj_valid_i;
  end

  a_r2_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> res_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !res_valid_o);

  a_r9_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!hit_o && hit_idx_o == '0));

  a_r9_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_idx_o != '0 && hit_idx_o <= IDX_W'(NUM_OBJ)));

  a_r9_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> hit_idx_o == '0);

  a_r5_hit_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> prev_valid[hit_idx_o - 1'b1]);
endmodule

bind can_accept_filter can_accept_filter_chk #(
  .NUM_OBJ (NUM_OBJ),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .obj_valid_i   (obj_valid_i),
  .res_valid_o   (res_valid_o),
  .hit_o         (hit_o),
  .hit_idx_o     (hit_idx_o)
);

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 15;
  localparam int IW = 29;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_valid = 1'b0;
  logic            frame_ext = 1'b0;
  logic [IW-1:0]   frame_id = '0;
  logic [NO*IW-1:0] obj_id = '0;
  logic [NO-1:0]   obj_ext = '0;
  logic [NO-1:0]   obj_valid = '0;
  logic [NO-2:0]   obj_rx = '0;
  logic [10:0]     std_mask = '1;
  logic [IW-1:0]   ext_mask = '1;
  logic [IW-1:0]   last_mask = '1;
  logic            res_valid, hit;
  logic [3:0]      hit_idx;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 0;
  logic   exp_hit_q[$];
  logic [3:0] exp_idx_q[$];
  string  tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter u_can_accept_filter (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(frame_valid), .frame_ext_i(frame_ext),
    .frame_id_i(frame_id), .obj_id_i(obj_id), .obj_ext_i(obj_ext), .obj_valid_i(obj_valid),
    .obj_rx_i(obj_rx), .std_mask_i(std_mask), .ext_mask_i(ext_mask), .last_mask_i(last_mask),
    .res_valid_o(res_valid), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_obj(input int n, input logic [IW-1:0] id, input logic ext,
                         input logic vld, input logic rx);
    obj_id[(n-1)*IW +: IW] = id;
    obj_ext[n-1] = ext;
    obj_valid[n-1] = vld;
    if (n < NO) obj_rx[n-1] = rx;
  endtask

  task automatic send(input logic [IW-1:0] id, input logic ext, input logic eh,
                      input logic [3:0] ei, input string tag);
    @(negedge clk);
    exp_hit_q.push_back(eh);
    exp_idx_q.push_back(ei);
    tag_q.push_back(tag);
    pushed++;
    frame_id = id;
    frame_ext = ext;
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    frame_id = '0;
  endtask

  // monitor: pops one expected item per result strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        if (exp_hit_q.size() == 0) begin
          check(1'b0, "R2 unexpected result strobe", 1, 0);
        end else begin
          logic eh; logic [3:0] ei; string t;
          eh = exp_hit_q.pop_front();
          ei = exp_idx_q.pop_front();
          t  = tag_q.pop_front();
          popped++;
          check(hit == eh && hit_idx == ei, t, {hit, hit_idx}, {eh, ei});
        end
      end else if (hit || hit_idx != 0) begin
        check(1'b0, "R9 outputs nonzero without strobe", {hit, hit_idx}, 0);
      end
    end
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 0 && hit == 0 && hit_idx == 0, "R1 in reset", {res_valid, hit, hit_idx}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(res_valid == 0 && hit == 0 && hit_idx == 0, "R1 after reset", {res_valid, hit, hit_idx}, 0);

    send(29'h123, 1'b0, 1'b0, 4'd0, "R5 R9 no enabled objects");
    set_obj(3, 29'h123, 1'b0, 1'b1, 1'b1);
    send(29'h123, 1'b0, 1'b1, 4'd3, "R3 exact standard match");
    send(29'h124, 1'b0, 1'b0, 4'd0, "R3 considered bit differs");
    send({18'h3FFFF, 11'h123}, 1'b0, 1'b1, 4'd3, "R4 upper bits ignored for standard");
    send(29'h123, 1'b1, 1'b0, 4'd0, "R5 format flag mismatch");
    std_mask = 11'h7F0;
    send(29'h12F, 1'b0, 1'b1, 4'd3, "R3 dont care bits");
    obj_rx[2] = 1'b0;
    send(29'h123, 1'b0, 1'b0, 4'd0, "R5 transmit object skipped");
    obj_rx[2] = 1'b1;
    set_obj(2, 29'h120, 1'b0, 1'b1, 1'b1);
    send(29'h12F, 1'b0, 1'b1, 4'd2, "R6 lowest object wins");
    obj_valid[1] = 1'b0;
    send(29'h12F, 1'b0, 1'b1, 4'd3, "R5 disabled object skipped");

    set_obj(5, 29'h1ABCDEF0, 1'b1, 1'b1, 1'b1);
    send(29'h1ABCDEF0, 1'b1, 1'b1, 4'd5, "R4 extended exact match");
    send(29'h1ABCDEF0 ^ 29'h100000, 1'b1, 1'b0, 4'd0, "R4 extended bit20 differs");
    ext_mask[20] = 1'b0;
    send(29'h1ABCDEF0 ^ 29'h100000, 1'b1, 1'b1, 4'd5, "R4 extended bit20 masked");

    set_obj(15, 29'h55, 1'b1, 1'b1, 1'b0);
    last_mask = 29'hFF;
    send(29'h1FFFFF55, 1'b1, 1'b1, 4'd15, "R8 catch-all local mask");
    set_obj(15, 29'hF0, 1'b1, 1'b1, 1'b0);
    send(29'h1ABCDEF0, 1'b1, 1'b1, 4'd5, "R7 general beats catch-all");
    obj_valid[4] = 1'b0;
    send(29'h1ABCDEF0, 1'b1, 1'b1, 4'd15, "R7 catch-all when general fails");

    last_mask = '1;
    ext_mask = ~29'h1;
    send(29'hF1, 1'b1, 1'b1, 4'd15, "R8 global clears bit0");
    ext_mask = '1;
    send(29'hF1, 1'b1, 1'b0, 4'd0, "R8 both masks consider bit0");
    last_mask = ~29'h1;
    send(29'hF1, 1'b1, 1'b1, 4'd15, "R8 local clears bit0");

    repeat (3) @(negedge clk);
    check(pushed == popped, "R2 result count", popped, pushed);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule